// File: doc/BRIEF.md
# Multi-Port General Register File with Constant Entries

This block is the main operand storage of a wide-issue processor core. It holds 128 words of 32 bits. Several issue slots read operands from it in the same cycle, and several result buses write into it in the same cycle. Each read port has its own address and returns the addressed word combinationally. Each write port has its own enable, address and data, and its write is committed on the rising clock edge.

The two lowest entries never change. Entry 0 always reads as all zeros, which software also uses as false and as single-precision +0.0. Entry 1 always reads as the integer one, which software also uses as true. These entries hold no storage. An enabled write aimed at either of them is dropped and reported on an error output for one cycle. Every other entry is plain storage. When two write ports collide on one entry, a fixed port priority settles which data is kept. A read and a write of the same entry in the same cycle return the value from before the write.

Top module: `gpr_file`

## Requirements
- R1: A read port addressing entry 0 returns 32'h0000_0000 in every cycle, whatever writes occurred earlier.
- R2: A read port addressing entry 1 returns 32'h0000_0001 in every cycle, whatever writes occurred earlier.
- R3: An enabled write to entry 0 or entry 1 leaves that entry's read value unchanged.
- R4: For each clock edge at which write port p is enabled with an address of 0 or 1, bit p of `illegal_port_o` is 1 during the following cycle, and 0 otherwise. `illegal_wr_o` is the OR of those bits.
- R5: An enabled write to an entry from 2 to 127 is returned by every read port that addresses that entry from the cycle after the clock edge, until a later write to that entry.
- R6: When several enabled write ports target the same entry at one edge, the data of the highest-numbered of those ports is kept.
- R7: A read of an entry that is written at the coming edge returns the value held before that edge.
- R8: While `rst_ni` is low, entries 2 to 127 clear to zero and `illegal_port_o` clears to 0.
- R9: A write port whose enable is 0 changes no entry and raises no flag, whatever its address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes commit on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_addr_i | input | NUM_RD x 7 | Address of each read port |
| rd_data_o | output | NUM_RD x 32 | Word returned to each read port, combinational |
| wr_en_i | input | NUM_WR | Enable of each write port |
| wr_addr_i | input | NUM_WR x 7 | Target entry of each write port |
| wr_data_i | input | NUM_WR x 32 | Data of each write port |
| illegal_wr_o | output | 1 | Some port tried to write a constant entry at the last edge |
| illegal_port_o | output | NUM_WR | Per-port flag for such an attempt at the last edge |

## Verification
The hardest case to reach is a cycle in which several write ports collide on one entry while a read port reads that same entry and another port aims at a constant entry. Uniform random addresses over 128 entries almost never produce this. The stimulus therefore sends about a quarter of all addresses into a narrow window of low entries, which covers the constant entries and a few stored ones, so collisions, same-cycle reads and flagged writes happen many times together. Directed cycles add a write by every port to one entry, writes to both constants, and disabled ports whose address and data point at live targets.

// File: rtl/rf_pkg.sv
package rf_pkg;

    // Number of hardwired entries at the bottom of the address space.
    localparam int unsigned RF_NUM_CONST = 2;

    // Value held by a hardwired entry: entry 0 is zero, entry 1 is one.
    function automatic logic [31:0] rf_const_word(input int unsigned idx);
        return (idx == 1) ? 32'h0000_0001 : 32'h0000_0000;
    endfunction

endpackage

// File: rtl/rf_wr_resolve.sv
// Turns the per-port write requests into per-entry enables and data.
// Ports are scanned in ascending order, so a higher port overrides a lower one.
module rf_wr_resolve #(
    parameter int unsigned DEPTH  = 128,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NUM_WR = 5,
    parameter int unsigned NCONST = 2,
    parameter int unsigned ADDR_W = 7,
    localparam int unsigned NSTORE = DEPTH - NCONST
) (
    input  logic [NUM_WR-1:0]             wr_en_i,
    input  logic [NUM_WR-1:0][ADDR_W-1:0] wr_addr_i,
    input  logic [NUM_WR-1:0][DATA_W-1:0] wr_data_i,
    output logic [NSTORE-1:0]             ent_we_o,
    output logic [NSTORE-1:0][DATA_W-1:0] ent_wdata_o,
    output logic [NUM_WR-1:0]             bad_mask_o
);

    always_comb begin
        ent_we_o    = '0;
        ent_wdata_o = '0;
        bad_mask_o  = '0;
        for (int p = 0; p < int'(NUM_WR); p++) begin
            if (wr_en_i[p]) begin
                if (int'(wr_addr_i[p]) < int'(NCONST)) begin
                    bad_mask_o[p] = 1'b1;
                end else if (int'(wr_addr_i[p]) < int'(DEPTH)) begin
                    ent_we_o[int'(wr_addr_i[p]) - int'(NCONST)]    = 1'b1;
                    ent_wdata_o[int'(wr_addr_i[p]) - int'(NCONST)] = wr_data_i[p];
                end
            end
        end
    end

endmodule

// File: rtl/rf_store.sv
// State of the file: stored entries and the registered illegal-write flags.
module rf_store #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NSTORE = 126,
    parameter int unsigned NUM_WR = 5
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [NSTORE-1:0]             ent_we_i,
    input  logic [NSTORE-1:0][DATA_W-1:0] ent_wdata_i,
    input  logic [NUM_WR-1:0]             bad_mask_i,
    output logic [NSTORE-1:0][DATA_W-1:0] ent_q_o,
    output logic [NUM_WR-1:0]             bad_q_o
);

    typedef struct packed {
        logic [NSTORE-1:0][DATA_W-1:0] ent;
        logic [NUM_WR-1:0]             bad;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < int'(NSTORE); i++) begin
            if (ent_we_i[i]) begin
                st_d.ent[i] = ent_wdata_i[i];
            end
        end
        st_d.bad = bad_mask_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ent_q_o = st_q.ent;
    assign bad_q_o = st_q.bad;

endmodule

// File: rtl/rf_read_port.sv
// One combinational read port. Constant entries come from the package, not storage.
module rf_read_port #(
    parameter int unsigned DEPTH  = 128,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NCONST = 2,
    parameter int unsigned ADDR_W = 7,
    localparam int unsigned NSTORE = DEPTH - NCONST
) (
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [NSTORE-1:0][DATA_W-1:0] ent_i,
    output logic [DATA_W-1:0]             data_o
);

    always_comb begin
        data_o = '0;
        if (int'(addr_i) < int'(NCONST)) begin
            data_o = DATA_W'(rf_pkg::rf_const_word(int'(unsigned'(addr_i))));
        end else if (int'(addr_i) < int'(DEPTH)) begin
            data_o = ent_i[int'(addr_i) - int'(NCONST)];
        end
    end

endmodule

// File: rtl/gpr_file.sv
module gpr_file #(
    parameter int unsigned DEPTH  = 128,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NUM_RD = 5,
    parameter int unsigned NUM_WR = 5,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr_i,
    output logic [NUM_RD-1:0][DATA_W-1:0] rd_data_o,
    input  logic [NUM_WR-1:0]             wr_en_i,
    input  logic [NUM_WR-1:0][ADDR_W-1:0] wr_addr_i,
    input  logic [NUM_WR-1:0][DATA_W-1:0] wr_data_i,
    output logic                          illegal_wr_o,
    output logic [NUM_WR-1:0]             illegal_port_o
);

    localparam int unsigned NCONST = rf_pkg::RF_NUM_CONST;
    localparam int unsigned NSTORE = DEPTH - NCONST;

    logic [NSTORE-1:0]             ent_we;
    logic [NSTORE-1:0][DATA_W-1:0] ent_wdata;
    logic [NSTORE-1:0][DATA_W-1:0] ent_q;
    logic [NUM_WR-1:0]             bad_d;
    logic [NUM_WR-1:0]             bad_q;

    rf_wr_resolve #(
        .DEPTH (DEPTH),
        .DATA_W(DATA_W),
        .NUM_WR(NUM_WR),
        .NCONST(NCONST),
        .ADDR_W(ADDR_W)
    ) u_resolve (
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .ent_we_o   (ent_we),
        .ent_wdata_o(ent_wdata),
        .bad_mask_o (bad_d)
    );

    rf_store #(
        .DATA_W(DATA_W),
        .NSTORE(NSTORE),
        .NUM_WR(NUM_WR)
    ) u_store (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ent_we_i   (ent_we),
        .ent_wdata_i(ent_wdata),
        .bad_mask_i (bad_d),
        .ent_q_o    (ent_q),
        .bad_q_o    (bad_q)
    );

    for (genvar r = 0; r < int'(NUM_RD); r++) begin : g_rd
        rf_read_port #(
            .DEPTH (DEPTH),
            .DATA_W(DATA_W),
            .NCONST(NCONST),
            .ADDR_W(ADDR_W)
        ) u_rd (
            .addr_i(rd_addr_i[r]),
            .ent_i (ent_q),
            .data_o(rd_data_o[r])
        );
    end

    assign illegal_port_o = bad_q;
    assign illegal_wr_o   = |bad_q;

endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
    parameter int unsigned DEPTH  = 128,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NUM_RD = 5,
    parameter int unsigned NUM_WR = 5,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input logic                          clk_i,
    input logic                          rst_ni,
    input logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr_i,
    input logic [NUM_RD-1:0][DATA_W-1:0] rd_data_o,
    input logic [NUM_WR-1:0]             wr_en_i,
    input logic [NUM_WR-1:0][ADDR_W-1:0] wr_addr_i,
    input logic [NUM_WR-1:0][DATA_W-1:0] wr_data_i,
    input logic                          illegal_wr_o,
    input logic [NUM_WR-1:0]             illegal_port_o
);

    logic any_bad;
    logic hit0;

    always_comb begin
        any_bad = 1'b0;
        hit0    = 1'b0;
        for (int p = 0; p < int'(NUM_WR); p++) begin
            if (wr_en_i[p] && int'(wr_addr_i[p]) < 2) any_bad = 1'b1;
            if (wr_en_i[p] && wr_addr_i[p] == rd_addr_i[0]) hit0 = 1'b1;
        end
    end

    for (genvar r = 0; r < int'(NUM_RD); r++) begin : g_rdchk
        // R1: entry 0 reads zero on every port
        p_zero_reads_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (rd_addr_i[r] == '0) |-> (rd_data_o[r] == '0));
        // R2: entry 1 reads one on every port
        p_one_reads_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (rd_addr_i[r] == ADDR_W'(1)) |-> (rd_data_o[r] == DATA_W'(1)));
    end

    // R4: an attempt on a constant entry raises the flag next cycle
    p_flag_raised_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_bad |=> illegal_wr_o);

    // R4: no attempt, no flag
    p_flag_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !any_bad |=> !illegal_wr_o);

    // R6: the top write port always lands, whatever lower ports do
    p_top_port_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i[NUM_WR-1] && int'(wr_addr_i[NUM_WR-1]) >= 2)
        |=> ((rd_addr_i[0] != $past(wr_addr_i[NUM_WR-1])) ||
             (rd_data_o[0] == $past(wr_data_i[NUM_WR-1]))));

    // R9: with no write hitting the read address, a held read stays put
    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hit0 |=> (!$stable(rd_addr_i[0]) || $stable(rd_data_o[0])));

endmodule

bind gpr_file gpr_file_chk #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W),
    .NUM_RD(NUM_RD),
    .NUM_WR(NUM_WR)
) u_chk (.*);

// File: tb/gpr_file_tb.sv
module gpr_file_tb;

    localparam int NRD = 5;
    localparam int NWR = 5;
    localparam int AW  = 7;
    localparam int DW  = 32;
    localparam int DEP = 128;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NRD-1:0][AW-1:0] rd_addr = '0;
    logic [NRD-1:0][DW-1:0] rd_data;
    logic [NWR-1:0]         wr_en = '0;
    logic [NWR-1:0][AW-1:0] wr_addr = '0;
    logic [NWR-1:0][DW-1:0] wr_data = '0;
    logic                   ill_any;
    logic [NWR-1:0]         ill_port;

    logic [DW-1:0] mdl [DEP];
    logic [NWR-1:0] exp_mask;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpr_file u_dut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .rd_addr_i     (rd_addr),
        .rd_data_o     (rd_data),
        .wr_en_i       (wr_en),
        .wr_addr_i     (wr_addr),
        .wr_data_i     (wr_data),
        .illegal_wr_o  (ill_any),
        .illegal_port_o(ill_port)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit written_now(input int a);
        for (int p = 0; p < NWR; p++) if (wr_en[p] && int'(wr_addr[p]) == a) return 1'b1;
        return 1'b0;
    endfunction

    // Check all read ports against the model (pre-edge contents).
    task automatic check_reads();
        #1;
        for (int r = 0; r < NRD; r++) begin
            int a;
            a = int'(rd_addr[r]);
            if (a == 0)              chk("R1 zero entry", rd_data[r], mdl[0]);
            else if (a == 1)         chk("R2 one entry", rd_data[r], mdl[1]);
            else if (written_now(a)) chk("R7 old value on same-cycle read", rd_data[r], mdl[a]);
            else                     chk("R5 stored value", rd_data[r], mdl[a]);
        end
    endtask

    // Commit current write inputs at the edge, update model, check flags.
    task automatic step();
        exp_mask = '0;
        for (int p = 0; p < NWR; p++)
            if (wr_en[p] && int'(wr_addr[p]) < 2) exp_mask[p] = 1'b1;
        @(posedge clk);
        for (int p = 0; p < NWR; p++)          // ascending: higher port wins (R6)
            if (wr_en[p] && int'(wr_addr[p]) >= 2) mdl[int'(wr_addr[p])] = wr_data[p];
        @(negedge clk);
        chk("R4 per-port flag", DW'(ill_port), DW'(exp_mask));
        chk("R4 any flag", DW'(ill_any), DW'(|exp_mask));
    endtask

    function automatic logic [AW-1:0] pick_addr();
        if ($urandom % 4 == 0) return AW'($urandom % 5);
        return AW'($urandom % DEP);
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEP; i++) mdl[i] = '0;
        mdl[1] = 32'h1;

        // Reset state (R8)
        repeat (3) @(negedge clk);
        chk("R8 flags in reset", DW'(ill_port), '0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int base = 0; base < DEP; base += NRD) begin
            for (int r = 0; r < NRD; r++) rd_addr[r] = AW'((base + r) % DEP);
            #1;
            for (int r = 0; r < NRD; r++) begin
                int a;
                a = (base + r) % DEP;
                if (a >= 2) chk("R8 entry cleared", rd_data[r], '0);
            end
            @(negedge clk);
        end
        chk("R8 flag after reset", DW'(ill_any), '0);

        // Directed: all ports collide on entry 9 (R6)
        wr_en = '1;
        for (int p = 0; p < NWR; p++) begin
            wr_addr[p] = AW'(9);
            wr_data[p] = 32'hA000_0000 + DW'(p);
        end
        rd_addr = '0;
        check_reads();
        step();
        wr_en = '0;
        rd_addr[0] = AW'(9);
        #1;
        chk("R6 highest port kept", rd_data[0], 32'hA000_0000 + DW'(NWR - 1));

        // Directed: writes to both constant entries (R3, R4)
        wr_en = '0;
        wr_en[0] = 1'b1; wr_addr[0] = AW'(0); wr_data[0] = 32'hDEAD_BEEF;
        wr_en[1] = 1'b1; wr_addr[1] = AW'(1); wr_data[1] = 32'hCAFE_F00D;
        wr_en[2] = 1'b1; wr_addr[2] = AW'(5); wr_data[2] = 32'h1234_5678;
        step();
        chk("R4 ports 0 and 1 flagged", DW'(ill_port), DW'(5'b00011));
        wr_en = '0;
        rd_addr[0] = AW'(0);
        rd_addr[1] = AW'(1);
        rd_addr[2] = AW'(5);
        #1;
        chk("R3 entry 0 unchanged", rd_data[0], 32'h0);
        chk("R3 entry 1 unchanged", rd_data[1], 32'h1);
        chk("R5 legal write beside illegal ones", rd_data[2], 32'h1234_5678);

        // Directed: disabled ports with live targets (R9)
        @(negedge clk);
        wr_en = '0;
        wr_addr[0] = AW'(0); wr_data[0] = 32'hFFFF_FFFF;
        wr_addr[1] = AW'(7); wr_data[1] = 32'h5555_AAAA;
        step();
        chk("R9 no flag from disabled port", DW'(ill_port), '0);
        rd_addr[0] = AW'(7);
        #1;
        chk("R9 entry 7 untouched", rd_data[0], mdl[7]);

        // Directed: read while writing same entry (R7)
        @(negedge clk);
        wr_en = '0;
        wr_en[3] = 1'b1; wr_addr[3] = AW'(20); wr_data[3] = 32'h0BAD_CAFE;
        rd_addr[0] = AW'(20);
        #1;
        chk("R7 same-cycle read sees old", rd_data[0], 32'h0);
        step();
        wr_en = '0;
        #1;
        chk("R5 new value next cycle", rd_data[0], 32'h0BAD_CAFE);

        // Constrained random
        for (int v = 0; v < 3000; v++) begin
            @(negedge clk);
            for (int p = 0; p < NWR; p++) begin
                wr_en[p]   = ($urandom % 3) != 0;
                wr_addr[p] = pick_addr();
                wr_data[p] = $urandom;
            end
            for (int r = 0; r < NRD; r++) rd_addr[r] = pick_addr();
            check_reads();
            step();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule